// File: doc/BRIEF.md
# Transmit Status Holding Pair

This block keeps the per-attempt transmit status of one Ethernet MAC port in two slots that the host reads through one shared address. The MAC presents a status word, a collision indication and a one-cycle strobe after every transmit attempt, whether it succeeded or failed. The block stores the word in a slot and sets that slot's fresh flag. When both slots hold unread words, host reads return them oldest first.

Three configuration inputs change how words are captured. A disable input stops all capture. A continuous mode always keeps the two most recent attempts, overwriting the older one, instead of holding words until they are read. A collision filter drops the status of any attempt that saw a collision. In the default latched mode, a word that arrives while both slots are unread is lost, and a sticky overflow flag records the loss.

Top module: `txstat_pair`

## Requirements
- R1: With all three configuration inputs low, a strobe stores its word. The next read returns that word with the fresh flag at 1 on `rd_fresh`.
- R2: A read clears the fresh flag of the slot it returns. A read while neither slot is fresh returns the most recently stored word, or 0 if nothing has been stored since reset, with `rd_fresh` at 0.
- R3: When both slots are fresh, the first read returns the earlier of the two words and the second read returns the later one.
- R4: In latched mode (`cfg_cont` low), a strobe that arrives while both slots are fresh is discarded and `ovf` goes to 1 on the next cycle. `ovf` stays at 1 until a read, and is 0 in the cycle after any read.
- R5: While `cfg_off` is 1, strobes store nothing. Reads see no new fresh word, and `ovf` is never set.
- R6: While `cfg_cont` is 1, every accepted strobe is stored and replaces the older slot, so the slots hold the two most recent words in arrival order. `ovf` is never set in this mode.
- R7: While `cfg_nocoll` is 1, a strobe with `st_coll` at 1 stores nothing.
- R8: When a strobe and a read fall in the same cycle, the read is served from the state before the strobe. The strobe's word then goes into a slot freed by that read, so this case does not raise `ovf`.
- R9: After reset, `rd_data`, `rd_fresh` and `ovf` are all 0.

Read results appear on `rd_data` and `rd_fresh` one cycle after `rd_en` and hold until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | One-cycle strobe: a transmit attempt finished |
| st_word | input | W | Status word of the attempt |
| st_coll | input | 1 | The attempt saw a collision |
| cfg_off | input | 1 | Disable all capture |
| cfg_cont | input | 1 | Continuous-update mode |
| cfg_nocoll | input | 1 | Drop status of collided attempts |
| rd_en | input | 1 | Host read of the shared status address |
| rd_data | output | W | Word returned by the last read |
| rd_fresh | output | 1 | Fresh flag of the word returned by the last read |
| ovf | output | 1 | Sticky flag: a word was lost in latched mode |

## Verification
The bench first runs short directed sequences. These separate oldest-first return from newest-first return, show that a read on an empty pair gives the stale word with the flag cleared, and show that a read served in the same cycle as a strobe frees a slot for that strobe. It then sweeps all eight settings of the configuration inputs. In each setting, pseudo-random patterns of strobes, collisions and reads are applied, and every read and the overflow flag are compared against a queue model that holds the unread words and the last stored word. Under these patterns, the disable and filter settings can be told apart from a design that stores regardless, and continuous mode can be told apart from latched mode by which word survives when both slots are full.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
    localparam int NSLOT = 2;

    typedef struct packed {
        logic last;   // index of the slot written most recently
        logic ovf;
    } ctrl_state_t;
endpackage

// File: rtl/txstat_filter.sv
module txstat_filter (
    input  logic st_valid,
    input  logic st_coll,
    input  logic cfg_off,
    input  logic cfg_nocoll,
    output logic accept
);
    always_comb begin
        accept = st_valid && !cfg_off && !(cfg_nocoll && st_coll);
    end
endmodule

// File: rtl/txstat_slot.sv
module txstat_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         clr,
    input  logic [W-1:0] word,
    output logic [W-1:0] data,
    output logic         fresh
);
    logic [W-1:0] data_d, data_q;
    logic         fresh_d, fresh_q;

    always_comb begin
        data_d  = data_q;
        fresh_d = fresh_q;
        if (clr) fresh_d = 1'b0;
        if (wr) begin
            data_d  = word;
            fresh_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            fresh_q <= 1'b0;
        end else begin
            data_q  <= data_d;
            fresh_q <= fresh_d;
        end
    end

    assign data  = data_q;
    assign fresh = fresh_q;

    AST_WR_SETS_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> fresh); // R1
endmodule

// File: rtl/txstat_ctrl.sv
module txstat_ctrl
    import txstat_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             cfg_cont,
    input  logic             rd_en,
    input  logic [NSLOT-1:0] fresh,
    input  logic [W-1:0]     sd0,
    input  logic [W-1:0]     sd1,
    output logic [NSLOT-1:0] wr,
    output logic [NSLOT-1:0] clr,
    output logic [W-1:0]     rd_data,
    output logic             rd_fresh,
    output logic             ovf
);
    typedef struct packed {
        ctrl_state_t  st;
        logic [W-1:0] rdat;
        logic         rfr;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic             sel, any_fresh, tgt, room;
    logic [NSLOT-1:0] left;

    always_comb begin
        s_d       = s_q;
        any_fresh = |fresh;
        // oldest fresh slot; the last-written slot when none is fresh
        if (&fresh)        sel = ~s_q.st.last;
        else if (fresh[0]) sel = 1'b0;
        else if (fresh[1]) sel = 1'b1;
        else               sel = s_q.st.last;

        clr = '0;
        if (rd_en && any_fresh) clr[sel] = 1'b1;
        left = fresh & ~clr;

        // write target chosen after the read has freed its slot
        tgt  = ~s_q.st.last;
        room = 1'b1;
        if (!cfg_cont) begin
            if (!left[~s_q.st.last])  tgt = ~s_q.st.last;
            else if (!left[s_q.st.last]) tgt = s_q.st.last;
            else room = 1'b0;
        end

        wr = '0;
        if (accept && room) begin
            wr[tgt]      = 1'b1;
            s_d.st.last  = tgt;
        end

        if (rd_en) begin
            s_d.rdat   = sel ? sd1 : sd0;
            s_d.rfr    = any_fresh;
            s_d.st.ovf = 1'b0;
        end else if (accept && !room) begin
            s_d.st.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st.last <= 1'b1;
            s_q.st.ovf  <= 1'b0;
            s_q.rdat    <= '0;
            s_q.rfr     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data  = s_q.rdat;
    assign rd_fresh = s_q.rfr;
    assign ovf      = s_q.st.ovf;

    AST_ONE_WRITE:    assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr)); // R1
    AST_EMPTY_READ:   assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && fresh == '0 |=> !rd_fresh); // R2
    AST_FULL_READ:    assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && fresh != '0 |=> rd_fresh); // R3
    AST_OVF_CLEARED:  assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !ovf); // R4
    AST_CONT_NO_OVF:  assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cont && !ovf |=> !ovf); // R6
    AST_RD_WR_ROOM:   assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && accept |=> $countones(fresh) >= 1); // R8
endmodule

// File: rtl/txstat_pair.sv
module txstat_pair
    import txstat_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         st_valid,
    input  logic [W-1:0] st_word,
    input  logic         st_coll,
    input  logic         cfg_off,
    input  logic         cfg_cont,
    input  logic         cfg_nocoll,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_fresh,
    output logic         ovf
);
    logic             accept;
    logic [NSLOT-1:0] wr, clr, fresh;
    logic [W-1:0]     sdat [NSLOT];

    txstat_filter u_filt (
        .st_valid   (st_valid),
        .st_coll    (st_coll),
        .cfg_off    (cfg_off),
        .cfg_nocoll (cfg_nocoll),
        .accept     (accept)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        txstat_slot #(.W(W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr[i]),
            .clr   (clr[i]),
            .word  (st_word),
            .data  (sdat[i]),
            .fresh (fresh[i])
        );
    end

    txstat_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cfg_cont (cfg_cont),
        .rd_en    (rd_en),
        .fresh    (fresh),
        .sd0      (sdat[0]),
        .sd1      (sdat[1]),
        .wr       (wr),
        .clr      (clr),
        .rd_data  (rd_data),
        .rd_fresh (rd_fresh),
        .ovf      (ovf)
    );

    AST_OFF_NO_STORE:  assert property (@(posedge clk) disable iff (!rst_n)
        cfg_off && !rd_en |=> $stable(fresh)); // R5
    AST_COLL_DROPPED:  assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_coll && cfg_nocoll && !rd_en |=> $stable(fresh)); // R7
endmodule

// File: tb/tb_txstat_pair.sv
`timescale 1ns/1ps
module tb_txstat_pair;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0, st_coll = 1'b0, rd_en = 1'b0;
    logic [W-1:0] st_word = '0;
    logic         cfg_off = 1'b0, cfg_cont = 1'b0, cfg_nocoll = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_fresh, ovf;

    int n_chk = 0, n_bad = 0;
    logic [W-1:0] uq [2];
    int           ucnt = 0;
    logic [W-1:0] lastw = '0;
    logic         m_ovf = 1'b0;
    logic [W-1:0] m_rd = '0;
    logic         m_fr = 1'b0;
    logic [15:0]  lfsr = 16'hACE1;

    always #2 clk = ~clk;

    txstat_pair #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_word(st_word),
        .st_coll(st_coll), .cfg_off(cfg_off), .cfg_cont(cfg_cont),
        .cfg_nocoll(cfg_nocoll), .rd_en(rd_en), .rd_data(rd_data),
        .rd_fresh(rd_fresh), .ovf(ovf)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle: inputs applied at a falling edge, results checked at the next one
    task automatic step(input logic v, input logic [W-1:0] w, input logic c,
                        input logic r, input string tag);
        logic acc;
        st_valid = v; st_word = w; st_coll = c; rd_en = r;
        @(posedge clk);
        acc = v && !cfg_off && !(cfg_nocoll && c);
        if (r) begin
            if (ucnt > 0) begin
                m_rd = uq[0]; m_fr = 1'b1; uq[0] = uq[1]; ucnt--;
            end else begin
                m_rd = lastw; m_fr = 1'b0;
            end
            m_ovf = 1'b0;
        end
        if (acc) begin
            if (cfg_cont) begin
                if (ucnt == 2) begin uq[0] = uq[1]; ucnt = 1; end
                uq[ucnt] = w; ucnt++; lastw = w;
            end else if (ucnt < 2) begin
                uq[ucnt] = w; ucnt++; lastw = w;
            end else if (!r) begin
                m_ovf = 1'b1;
            end
        end
        @(negedge clk);
        st_valid = 1'b0; rd_en = 1'b0;
        if (r) begin
            check({tag, " data"}, int'(rd_data), int'(m_rd));
            check({tag, " fresh"}, int'(rd_fresh), int'(m_fr));
        end
        check({tag, " ovf"}, int'(ovf), int'(m_ovf));
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R9 data", int'(rd_data), 0);
        check("R9 fresh", int'(rd_fresh), 0);
        check("R9 ovf", int'(ovf), 0);
        step(0, 0, 0, 1, "R2 empty");
        step(1, 8'h11, 0, 0, "R1");
        step(0, 0, 0, 1, "R1 read");
        step(0, 0, 0, 1, "R2 stale");
        step(1, 8'h22, 0, 0, "R3");
        step(1, 8'h33, 0, 0, "R3");
        step(1, 8'h44, 0, 0, "R4 drop");
        step(0, 0, 0, 0, "R4 sticky");
        step(0, 0, 0, 1, "R3 oldest");
        step(0, 0, 0, 1, "R3 newer");
        step(0, 0, 0, 1, "R2 stale");
        step(1, 8'h55, 0, 0, "R8");
        step(1, 8'h66, 0, 0, "R8");
        step(1, 8'h77, 0, 1, "R8 same");
        step(0, 0, 0, 1, "R8 next");
        step(0, 0, 0, 1, "R8 last");
        for (int cfg = 0; cfg < 8; cfg++) begin
            string tag;
            cfg_off = cfg[0]; cfg_cont = cfg[1]; cfg_nocoll = cfg[2];
            tag = cfg_off ? "R5" : cfg_nocoll ? "R7" : cfg_cont ? "R6" : "R4";
            for (int k = 0; k < 400; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[0] | lfsr[5], W'(k + cfg * 64), lfsr[2], lfsr[3] & lfsr[7], tag);
            end
            for (int k = 0; k < 3; k++) step(0, 0, 0, 1, tag);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule